// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block sits between a small controller's interrupt sources and its instruction sequencer. It watches a system reset request, a one-cycle software trap strobe and fourteen peripheral request slots. Each cycle it picks the single most urgent pending request and hands the sequencer a one-cycle take pulse, the 16-bit address of the vector word to fetch, and the priority level of the winner. Seven of the fourteen slots carry real sources: two external pin groups, a clock-failure monitor, a serial peripheral interface, two timers and an I2C controller. The remaining slots are permanently dead.

Peripheral requests are level-sensitive and remain asserted until the owning peripheral clears its flag, so the arbiter only samples them. A global interrupt-mask input blocks all slot requests but never reset or the trap. The trap strobe is remembered until it is taken. While the core is halted, a separate wake output tells the clock controller that a source able to end HALT is requesting. Only reset and the two external pin groups have that ability.

Top module: `irq_vector_arb`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, take_o=0, vec_o=16'hFFFE, src_o=0 and wake_o=0.
- R2: Priority levels are ordered with lowest level winning: level 0 is reset_req_i, level 1 is the software trap, and slot k of irq_req_i is level k+2.
- R3: On a take, src_o equals the winning level and vec_o equals 16'hFFFE minus twice that level, so the trap gives FFFC, slot 0 gives FFFA and slot 13 gives FFE0.
- R4: Slots 5, 7, 8, 9, 10, 12 and 13 (unused mask 14'h37A0, used mask 14'h085F) never produce a take, even when their request bits are high.
- R5: While imask_i is 1, no slot request is taken. Reset and the trap are still taken.
- R6: A trap_i strobe that cannot be taken in its own cycle stays pending until it wins a take, and it is cleared by that take.
- R7: take_o goes high one clock after the sampled request, for exactly one cycle. The cycle after a take never carries another take. vec_o and src_o change only together with take_o and hold their value otherwise.
- R8: wake_o is high one clock after a cycle in which halt_i=1 and either reset_req_i or slot 0 or slot 1 is requesting, regardless of imask_i. The trap and all other slots never raise it.
- R9: A slot request held high is taken again after each gap cycle for as long as it remains the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_req_i | input | 1 | System reset request, highest priority, never masked |
| trap_i | input | 1 | One-cycle software trap strobe |
| irq_req_i | input | 14 | Level requests of slots 0 to 13 |
| imask_i | input | 1 | Global interrupt mask; 1 blocks the slots |
| halt_i | input | 1 | Core is in HALT |
| take_o | output | 1 | One-cycle interrupt take pulse |
| vec_o | output | 16 | Vector address of the winner |
| src_o | output | 4 | Priority level of the winner |
| wake_o | output | 1 | HALT exit request |

## Verification
The sharpest collision is between a trap strobe and the enforced gap cycle after a take. The trap arrives while the arbiter is locked out, and its latched copy must still win one cycle later over any slot still pending. The bench provokes this directly by striking the trap in the cycle right after a slot take. Random runs cover many more such cases, with dense requests, mask toggles and trap strobes. A second overlap is the take and the wake decision for the same slot 0 or slot 1 request while halt_i is high. A cycle-level reference model in the bench judges every output in every cycle.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int unsigned SLOT_CNT  = 14;
  localparam int unsigned VEC_WIDTH = 16;
  localparam logic [SLOT_CNT-1:0]  SLOT_USED = 14'h085F;  // slots 0-4, 6, 11
  localparam logic [SLOT_CNT-1:0]  SLOT_WAKE = 14'h0003;  // external pin groups
  localparam logic [VEC_WIDTH-1:0] VEC_HIGH  = 16'hFFFE;
endpackage

// File: rtl/irq_src_gate.sv
`timescale 1ns/1ps
module irq_src_gate #(
  parameter int unsigned        N_SLOT = 14,
  parameter logic [N_SLOT-1:0]  USED   = '1,
  parameter logic [N_SLOT-1:0]  WAKE   = '0
) (
  input  logic              reset_req_i,
  input  logic              trap_req_i,
  input  logic [N_SLOT-1:0] irq_req_i,
  input  logic              imask_i,
  input  logic              halt_i,
  output logic [N_SLOT+1:0] lvl_req_o,
  output logic              wake_o
);
  assign lvl_req_o[0] = reset_req_i;
  assign lvl_req_o[1] = trap_req_i;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    if (USED[k]) begin : g_live
      assign lvl_req_o[k+2] = irq_req_i[k] & ~imask_i;
    end else begin : g_dead
      // tie dead slots off so a stray input cannot win
      assign lvl_req_o[k+2] = irq_req_i[k] & 1'b0;
    end
  end

  assign wake_o = halt_i & (reset_req_i | (|(irq_req_i & WAKE)));
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !valid_o) begin
        valid_o    = 1'b1;
        idx_o      = IDX_W'(i);
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vector_arb.sv
`timescale 1ns/1ps
module irq_vector_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned        N_SLOT    = SLOT_CNT,
  parameter logic [N_SLOT-1:0]  USED_MASK = SLOT_USED,
  parameter logic [N_SLOT-1:0]  WAKE_MASK = SLOT_WAKE,
  parameter int unsigned        VEC_W     = VEC_WIDTH,
  parameter logic [VEC_W-1:0]   VEC_TOP   = VEC_HIGH,
  localparam int unsigned       N_LVL     = N_SLOT + 2,
  localparam int unsigned       LVL_W     = $clog2(N_LVL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_req_i,
  input  logic              trap_i,
  input  logic [N_SLOT-1:0] irq_req_i,
  input  logic              imask_i,
  input  logic              halt_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [LVL_W-1:0]  src_o,
  output logic              wake_o
);
  logic             trap_pend_q;
  logic             trap_any;
  logic [N_LVL-1:0] lvl_req;
  logic [N_LVL-1:0] win_gnt;
  logic [LVL_W-1:0] win_idx;
  logic             win_vld;
  logic             wake_d;
  logic             accept;
  logic [VEC_W-1:0] vec_d;

  assign trap_any = trap_pend_q | trap_i;

  irq_src_gate #(
    .N_SLOT (N_SLOT),
    .USED   (USED_MASK),
    .WAKE   (WAKE_MASK)
  ) u_gate (
    .reset_req_i (reset_req_i),
    .trap_req_i  (trap_any),
    .irq_req_i   (irq_req_i),
    .imask_i     (imask_i),
    .halt_i      (halt_i),
    .lvl_req_o   (lvl_req),
    .wake_o      (wake_d)
  );

  irq_prio_enc #(
    .N     (N_LVL),
    .IDX_W (LVL_W)
  ) u_enc (
    .req_i   (lvl_req),
    .valid_o (win_vld),
    .idx_o   (win_idx),
    .grant_o (win_gnt)
  );

  // one lockout cycle after every take gives the core time to set the mask
  assign accept = win_vld & ~take_o;
  assign vec_d  = VEC_TOP - VEC_W'({win_idx, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o      <= 1'b0;
      vec_o       <= VEC_TOP;
      src_o       <= '0;
      wake_o      <= 1'b0;
      trap_pend_q <= 1'b0;
    end else begin
      take_o      <= accept;
      wake_o      <= wake_d;
      trap_pend_q <= trap_any & ~(accept & win_gnt[1]);
      if (accept) begin
        vec_o <= vec_d;
        src_o <= win_idx;
      end
    end
  end

  function automatic logic lvl_is_live(input logic [LVL_W-1:0] lvl);
    logic live;
    live = (lvl < LVL_W'(2));
    for (int k = 0; k < int'(N_SLOT); k++)
      if (lvl == LVL_W'(k + 2)) live = USED_MASK[k];
    return live;
  endfunction

  AST_TAKE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o) else $error("take repeated");  // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> ($stable(vec_o) && $stable(src_o))) else $error("vector moved");  // R7
  AST_DEAD_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> lvl_is_live(src_o)) else $error("dead slot taken");  // R4
  AST_MASK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(imask_i)) |-> (src_o < LVL_W'(2))) else $error("masked slot taken");  // R5
  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reset_req_i) && !$past(take_o)) |-> (take_o && src_o == '0)) else $error("reset lost");  // R2
  AST_WAKE_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(halt_i)) else $error("wake outside halt");  // R8
endmodule

// File: tb/tb_irq_vector_arb.sv
`timescale 1ns/1ps
module tb_irq_vector_arb;
  localparam logic [13:0] USED = 14'h085F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0;
  logic        trap = 1'b0;
  logic [13:0] irq = '0;
  logic        imask = 1'b0;
  logic        halt = 1'b0;
  logic        take;
  logic [15:0] vec;
  logic [3:0]  src;
  logic        wake;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit          m_take = 0;
  logic [15:0] m_vec = 16'hFFFE;
  int          m_src = 0;
  bit          m_wake = 0;
  bit          m_pend = 0;

  always #2.5 clk = ~clk;

  irq_vector_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .reset_req_i(reset_req), .trap_i(trap),
    .irq_req_i(irq), .imask_i(imask), .halt_i(halt),
    .take_o(take), .vec_o(vec), .src_o(src), .wake_o(wake)
  );

  function automatic int win_level(bit rr, bit pend, logic [13:0] rq, bit im);
    if (rr) return 0;
    if (pend) return 1;
    if (!im)
      for (int k = 0; k < 14; k++)
        if (rq[k] && USED[k]) return k + 2;
    return -1;
  endfunction

  task automatic check(string tag);
    total++;
    if (take !== m_take || vec !== m_vec || int'(src) != m_src || wake !== m_wake) begin
      bad++;
      $display("FAIL %s take=%0b/%0b vec=%h/%h src=%0d/%0d wake=%0b/%0b",
               tag, take, m_take, vec, m_vec, src, m_src, wake, m_wake);
    end
  endtask

  task automatic step(bit rr, bit tr, logic [13:0] rq, bit im, bit hl, string tag);
    bit pend;
    int lvl;
    bit acc;
    reset_req = rr; trap = tr; irq = rq; imask = im; halt = hl;
    pend = m_pend | tr;
    lvl  = win_level(rr, pend, rq, im);
    acc  = (lvl >= 0) && !m_take;
    m_wake = hl && (rr || rq[0] || rq[1]);
    m_pend = pend && !(acc && lvl == 1);
    m_take = acc;
    if (acc) begin
      m_src = lvl;
      m_vec = 16'hFFFE - 16'(2 * lvl);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, '0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 after release");

    // each slot alone: live slots win, dead slots never do
    for (int k = 0; k < 14; k++) begin
      step(0, 0, 14'(1) << k, 0, 0, USED[k] ? "R3 live slot" : "R4 dead slot");
      idle("R7 gap");
      idle("R7 hold");
    end
    step(0, 0, 14'h37A0, 0, 0, "R4 all dead slots");
    idle("R4 idle");

    // mask blocks slots but not trap or reset
    step(0, 0, '1, 1, 0, "R5 masked slots");
    step(0, 1, '1, 1, 0, "R5 trap unmasked");
    idle("R7 gap");
    step(1, 1, '1, 1, 0, "R2 reset beats trap");
    step(0, 0, '0, 0, 0, "R6 trap still pending");
    step(0, 0, '0, 0, 0, "R6 trap taken");
    idle("R6 trap cleared");

    // trap strobe during lockout cycle
    step(0, 0, 14'h0008, 0, 0, "R2 slot 3");
    step(0, 1, 14'h0008, 0, 0, "R6 trap in gap");
    step(0, 0, 14'h0008, 0, 0, "R6 latched trap wins");
    step(0, 0, '0, 0, 0, "R7 gap");
    idle("R6 idle");

    // level request retaken
    for (int i = 0; i < 5; i++) step(0, 0, 14'h0010, 0, 0, "R9 held level");
    step(0, 0, 14'h0850, 0, 0, "R2 slot 4 over 6 and 11");
    idle("R2 idle");

    // wake behaviour
    step(0, 0, 14'h0004, 1, 1, "R8 no wake clock monitor");
    step(0, 0, 14'h0002, 1, 1, "R8 wake slot 1 masked");
    step(0, 1, '0, 0, 1, "R8 no wake trap");
    step(0, 0, 14'h0001, 0, 0, "R8 no wake outside halt");
    step(1, 0, '0, 0, 1, "R8 wake reset");
    idle("R8 idle");
    idle("R8 idle");

    // constrained random
    void'($urandom(32'h5EED));
    for (int n = 0; n < 4000; n++) begin
      logic [13:0] rq;
      rq = 14'($urandom) & 14'($urandom);
      step(($urandom % 40) == 0, ($urandom % 8) == 0, rq,
           ($urandom % 3) == 0, ($urandom % 4) == 0, "R2 R3 R5 R6 R8 random");
    end
    finish_run();
  end
endmodule